// File: doc/BRIEF.md
# Transceiver Channel Control Latch Bank

This block holds the static control state of a two-channel serial transceiver. A single 4-bit enable bus is shared by three level-sensitive latches. One sets the serial driver enables, one sets the receive channel power enables, and one sets the built-in self-test (BIST) selection. Each latch has its own active-high load input. While that input is high the latch is transparent and its outputs follow the bus. When the load input falls, the latch keeps the bus value it last saw.

Board logic can therefore program all three latches over the same four wires. It places a value on the bus and pulses the load input of the latch it wants to set. The BIST latch uses inverted polarity: a 0 bit turns BIST on. The block also produces a registered, active-low link fault flag for each channel. The flag combines three synchronous status inputs with the state of that channel's receive enable.

Top module: `xcvr_ctl_latches`

## Requirements
- R1: While a latch's load input (oeLe, rxLe, bistLe) is high, that latch's outputs follow enBus with no clock edge needed.
- R2: When a load input falls, the latch keeps the enBus value it had just before the fall, and later bus changes have no effect on its outputs.
- R3: serEn[i] equals bit i of the output-enable latch (1 = driver on, 0 = powered down). The driver order is bits 0..3 = channel A driver 1, channel A driver 2, channel B driver 1, channel B driver 2.
- R4: rxChanEn[0] (channel A) equals bit 0 of the receive-enable latch, and rxChanEn[1] (channel B) equals bit 2. A 1 makes the channel active.
- R5: The BIST latch has inverted polarity: a 0 bit selects BIST. txBistOn[0] = ~bit1, txBistOn[1] = ~bit3, rxBistOn[0] = ~bit0 and rxBistOn[1] = ~bit2. The txBistOn and rxBistOn outputs are active high.
- R6: While rstN is low, serEn = 0, rxChanEn = 0, txBistOn = 0, rxBistOn = 0 and linkFaultN = 0, whatever the load inputs are doing. Reset takes priority over a transparent latch.
- R7: After each rising clk edge, linkFaultN[c] equals the inverse of (freqErr[c] | ampLow[c] | densLow[c] | ~rxChanEn[c]) as sampled at that edge. It changes only on clk edges.
- R8: When several load inputs are high at once, each of those latches loads the same enBus value on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the link fault register |
| rstN | input | 1 | Asynchronous active-low reset |
| enBus | input | 4 | Shared enable bus |
| oeLe | input | 1 | Load input of the output-enable latch |
| rxLe | input | 1 | Load input of the receive-enable latch |
| bistLe | input | 1 | Load input of the BIST latch |
| freqErr | input | 2 | Per-channel frequency-out-of-range status |
| ampLow | input | 2 | Per-channel low-amplitude status |
| densLow | input | 2 | Per-channel low-transition-density status |
| serEn | output | 4 | Serial driver enables, order A1, A2, B1, B2 |
| rxChanEn | output | 2 | Receive channel enables, bit 0 = A |
| txBistOn | output | 2 | Transmit BIST active, bit 0 = A |
| rxBistOn | output | 2 | Receive BIST active, bit 0 = A |
| linkFaultN | output | 2 | Registered active-low link fault flag |

## Verification
Two kinds of event can land in the same cycle. In the first, several load inputs are open together; in the second, reset arrives while latches are transparent. The bench holds all three load inputs high during reset and at a later mid-run reset, and expects every output to stay at its safe value. It also opens all three latches on one bus value and then closes them, and expects each one to keep that value. A behavioural reference model is compared against every output on every clock. It also checks that the link fault flag picks up a change in receive enable one edge later.

// File: rtl/xcvr_ctl_pkg.sv
package xcvr_ctl_pkg;
  localparam int BUS_W  = 4;
  localparam int NUM_CH = 2;

  // Load strobes handed from control to datapath
  typedef struct packed {
    logic clear;
    logic loadOe;
    logic loadRx;
    logic loadBist;
  } latchStrobes_t;
endpackage

// File: rtl/xcvr_ctl_control.sv
module xcvr_ctl_control
  import xcvr_ctl_pkg::*;
(
  input  logic          rstN,
  input  logic          oeLe,
  input  logic          rxLe,
  input  logic          bistLe,
  output latchStrobes_t strobes
);
  always_comb begin
    strobes.clear    = ~rstN;
    // reset wins over any transparent load enable
    strobes.loadOe   = oeLe   & rstN;
    strobes.loadRx   = rxLe   & rstN;
    strobes.loadBist = bistLe & rstN;
  end
endmodule

// File: rtl/xcvr_ctl_latch.sv
module xcvr_ctl_latch #(
  parameter int          WIDTH = 4,
  parameter logic [WIDTH-1:0] SAFE = '0
) (
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_latch begin
    if (clear)     q = SAFE;
    else if (load) q = d;
  end
endmodule

// File: rtl/xcvr_ctl_datapath.sv
module xcvr_ctl_datapath
  import xcvr_ctl_pkg::*;
#(
  parameter int BW = BUS_W,
  parameter int NC = NUM_CH
) (
  input  logic          clk,
  input  latchStrobes_t strobes,
  input  logic [BW-1:0] enBus,
  input  logic [NC-1:0] freqErr,
  input  logic [NC-1:0] ampLow,
  input  logic [NC-1:0] densLow,
  output logic [BW-1:0] serEn,
  output logic [NC-1:0] rxChanEn,
  output logic [NC-1:0] txBistOn,
  output logic [NC-1:0] rxBistOn,
  output logic [NC-1:0] linkFaultN
);
  localparam int BITS_PER_CH = BW / NC;
  localparam logic [BW-1:0] BIST_SAFE = '1;  // all ones = normal operation

  logic [BW-1:0] oeQ, rxQ, bistQ;

  xcvr_ctl_latch #(.WIDTH(BW), .SAFE('0)) uOe (
    .clear(strobes.clear), .load(strobes.loadOe), .d(enBus), .q(oeQ));
  xcvr_ctl_latch #(.WIDTH(BW), .SAFE('0)) uRx (
    .clear(strobes.clear), .load(strobes.loadRx), .d(enBus), .q(rxQ));
  xcvr_ctl_latch #(.WIDTH(BW), .SAFE(BIST_SAFE)) uBist (
    .clear(strobes.clear), .load(strobes.loadBist), .d(enBus), .q(bistQ));

  assign serEn = oeQ;

  for (genvar c = 0; c < NC; c++) begin : gCh
    localparam int RX_BIT = c * BITS_PER_CH;
    localparam int TX_BIT = c * BITS_PER_CH + 1;
    logic faultAny;

    assign rxChanEn[c] = rxQ[RX_BIT];
    assign rxBistOn[c] = ~bistQ[RX_BIT];
    assign txBistOn[c] = ~bistQ[TX_BIT];
    assign faultAny    = freqErr[c] | ampLow[c] | densLow[c] | ~rxQ[RX_BIT];

    always_ff @(posedge clk or posedge strobes.clear) begin
      if (strobes.clear) linkFaultN[c] <= 1'b0;
      else               linkFaultN[c] <= ~faultAny;
    end
  end
endmodule

// File: rtl/xcvr_ctl_latches.sv
module xcvr_ctl_latches
  import xcvr_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] enBus,
  input  logic       oeLe,
  input  logic       rxLe,
  input  logic       bistLe,
  input  logic [1:0] freqErr,
  input  logic [1:0] ampLow,
  input  logic [1:0] densLow,
  output logic [3:0] serEn,
  output logic [1:0] rxChanEn,
  output logic [1:0] txBistOn,
  output logic [1:0] rxBistOn,
  output logic [1:0] linkFaultN
);
  latchStrobes_t strobes;

  xcvr_ctl_control uCtl (
    .rstN(rstN), .oeLe(oeLe), .rxLe(rxLe), .bistLe(bistLe), .strobes(strobes));

  xcvr_ctl_datapath #(.BW(BUS_W), .NC(NUM_CH)) uDp (
    .clk(clk), .strobes(strobes), .enBus(enBus),
    .freqErr(freqErr), .ampLow(ampLow), .densLow(densLow),
    .serEn(serEn), .rxChanEn(rxChanEn), .txBistOn(txBistOn),
    .rxBistOn(rxBistOn), .linkFaultN(linkFaultN));
endmodule

// File: rtl/xcvr_ctl_checker.sv
module xcvr_ctl_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] enBus,
  input logic       oeLe,
  input logic       rxLe,
  input logic       bistLe,
  input logic [1:0] freqErr,
  input logic [1:0] ampLow,
  input logic [1:0] densLow,
  input logic [3:0] serEn,
  input logic [1:0] rxChanEn,
  input logic [1:0] txBistOn,
  input logic [1:0] rxBistOn,
  input logic [1:0] linkFaultN
);
  // R1, R3: transparent output-enable latch
  a_r1_oe_follows: assert property (@(posedge clk) disable iff (!rstN)
    oeLe |-> serEn == enBus);
  // R4: transparent receive-enable latch mapping
  a_r4_rx_follows: assert property (@(posedge clk) disable iff (!rstN)
    rxLe |-> rxChanEn == {enBus[2], enBus[0]});
  // R5: inverted BIST polarity
  a_r5_bist_inverted: assert property (@(posedge clk) disable iff (!rstN)
    bistLe |-> (txBistOn == ~{enBus[3], enBus[1]}) && (rxBistOn == ~{enBus[2], enBus[0]}));
  // R2: closed latch holds
  a_r2_oe_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!oeLe && $past(!oeLe) && $past(rstN)) |-> $stable(serEn));
  // R7: registered link fault
  a_r7_fault_reg: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> linkFaultN ==
      ~($past(freqErr) | $past(ampLow) | $past(densLow) | ~$past(rxChanEn)));
  // R6: safe state under reset
  always @(posedge clk) begin
    if (!rstN) begin
      a_r6_reset_safe: assert (serEn == 4'b0 && rxChanEn == 2'b0 && txBistOn == 2'b0
                               && rxBistOn == 2'b0 && linkFaultN == 2'b0);
    end
  end
endmodule

bind xcvr_ctl_latches xcvr_ctl_checker uChk (.*);

// File: tb/tb_xcvr_ctl_latches.sv
`timescale 1ns/1ps
module tb_xcvr_ctl_latches;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] enBus = 4'hF;
  logic       oeLe = 1'b1, rxLe = 1'b1, bistLe = 1'b1;
  logic [1:0] freqErr = '0, ampLow = '0, densLow = '0;
  logic [3:0] serEn;
  logic [1:0] rxChanEn, txBistOn, rxBistOn, linkFaultN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  xcvr_ctl_latches dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit [3:0] mOe, mRx, mBist;
  bit [1:0] pendFault, expFault;
  bit prevRst = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit [1:0] rxM;
      if (!rstN) begin
        mOe = 4'h0; mRx = 4'h0; mBist = 4'hF;   // R6 safe values
      end else begin
        if (oeLe)   mOe   = enBus;
        if (rxLe)   mRx   = enBus;
        if (bistLe) mBist = enBus;
      end
      expFault = (rstN && prevRst) ? pendFault : 2'b00;
      rxM = {mRx[2], mRx[0]};
      check(rstN ? "R1/R2/R3 serEn" : "R6 serEn", serEn, mOe);
      check(rstN ? "R4 rxChanEn" : "R6 rxChanEn", rxChanEn, rxM);
      check(rstN ? "R5 txBistOn" : "R6 txBistOn", txBistOn, ~{mBist[3], mBist[1]} & 2'b11);
      check(rstN ? "R5 rxBistOn" : "R6 rxBistOn", rxBistOn, ~{mBist[2], mBist[0]} & 2'b11);
      check(rstN ? "R7 linkFaultN" : "R6 linkFaultN", linkFaultN, expFault);
      pendFault = ~(freqErr | ampLow | densLow | ~rxM);
      prevRst = rstN;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R6: reset held with all load inputs open
    step(3);
    rstN = 1'b1; oeLe = 0; rxLe = 0; bistLe = 0; enBus = 4'h0;
    step(2);
    // R1/R3: transparent output-enable latch
    oeLe = 1; enBus = 4'h5; step(2);
    enBus = 4'hA; step(2);
    // R2: close, then disturb bus
    oeLe = 0; step(1);
    enBus = 4'h3; step(2);
    // R4/R7: enable channel A receive only, toggle fault status
    rxLe = 1; enBus = 4'h1; step(1);
    rxLe = 0; step(1);
    enBus = 4'hF; step(2);
    freqErr = 2'b01; step(2);
    freqErr = 2'b00; ampLow = 2'b10; step(2);
    rxLe = 1; enBus = 4'h4; step(1);
    rxLe = 0; step(1);
    ampLow = 2'b00; densLow = 2'b10; step(2);
    densLow = 2'b00; step(2);
    // R5: BIST on everywhere, then only transmit A
    bistLe = 1; enBus = 4'h0; step(2);
    enBus = 4'hD; step(1);
    bistLe = 0; step(1);
    enBus = 4'h0; step(2);
    // R8: all three open on one value, close together
    oeLe = 1; rxLe = 1; bistLe = 1; enBus = 4'h6; step(2);
    oeLe = 0; rxLe = 0; bistLe = 0; step(1);
    enBus = 4'h9; step(2);
    // R8: two open, one closed
    oeLe = 1; bistLe = 1; enBus = 4'hB; step(2);
    oeLe = 0; bistLe = 0; step(2);
    // R6: mid-run reset while all load inputs open
    oeLe = 1; rxLe = 1; bistLe = 1; enBus = 4'hF; step(1);
    rstN = 0; step(3);
    oeLe = 0; rxLe = 0; bistLe = 0; step(1);
    rstN = 1; step(3);
    rxLe = 1; enBus = 4'h5; step(1);
    rxLe = 0; step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule